// File: doc/BRIEF.md
# One-Time-Programmable Row Array Command Front End

This block puts a small register file in front of an array of one-time-programmable rows. Software fills in a row address and write data, picks a command code, and raises a start bit. The command runs for a fixed number of busy cycles. When it finishes, the block sets a sticky done flag that software clears by writing 1 to it.

Each row holds 32 data bits and a 9-bit extension field used for check bits. A read copies the row into two result registers. While checking is enabled, the read also flags a mismatch between the stored check bits and a fold of the data bits.

Programming is guarded. Four unlock commands must first carry a fixed key in order, and only then is a single program command accepted. Programming can only set bits.

Top module: `otp_cmd_front`

## Requirements
- R1: After reset every register reads zero, except status 0 (index 5), which reads 0x8: ready at bit 3 set, program-OK at bit 2 clear.
- R2: Register indices are: program control 0, write data low 1, write data high 2, row address 3, control 4, status 0 5, status 1 6, read data low 7, read data high 8. Program control keeps only bits 15 (array access enable), 9 (check disable) and 8 (extension write enable). Row address keeps bits 15:6. Write data high keeps bits 8:0. Control keeps bits 4:0, with bit 0 as start and bits 4:1 as command code. Other bits read as zero.
- R3: A command is launched only when the start bit changes from 0 to 1 while access enable is 1 and the block is ready. Writing start while it is already 1, or while access enable is 0, launches nothing.
- R4: After the clock edge that launches a command, ready (status 0 bit 3) is low and done (status 1 bit 1) stays clear for BUSY_CYCLES edges. Both are set at the BUSY_CYCLES-th edge after launch.
- R5: Done is cleared by a write to status 1 with bit 1 set. Writing 0 there leaves it set.
- R6: Four consecutive unlock commands (code 2) whose write-data-low values are 0xF, 0x4, 0x8 and 0xD, in that order, set program-OK (status 0 bit 2).
- R7: A wrong key value, or any other command in the middle of the unlock sequence, restarts the sequence at its first step.
- R8: While access enable is 0, program-OK is cleared and the unlock sequence restarts.
- R9: A program command (code 10) issued without program-OK leaves the addressed row unchanged.
- R10: A program command with program-OK ORs write-data-low into the row's data bits. It ORs write-data-high[8:0] into the extension bits only when extension write enable is 1. It clears program-OK.
- R11: A read command (code 0) places the addressed row's data bits in read data low and its extension bits in read data high bits 8:0.
- R12: Status 1 bit 17 is updated by each read. It is 1 when check disable is 0 and the stored extension bits differ from the fold of the data bits, where fold bit j is the XOR of all data bits i with i mod 9 = j. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is registered on this edge |
| bus_rdata | output | 32 | Registered read data |

## Verification
Read data is captured at the edge where the read strobe is sampled, so a register read shows the state left by the previous edge. Done and ready change at the BUSY_CYCLES-th edge after the launch edge. The first status read that can show them set is therefore the one that captures at launch plus BUSY_CYCLES plus 1. The latency check reads status 1 on every edge after the launch and expects exactly BUSY_CYCLES clear readings before the first set one. All other command checks poll done with a bounded loop, clear it, and only then read the result registers, so they never sample results mid-command.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  localparam int DATA_W = 32;
  localparam int EXT_W  = 9;
  localparam int ROW_W  = DATA_W + EXT_W;
  localparam int REG_AW = 4;
  localparam int CMD_W  = 4;
  localparam int KEY_LEN = 4;

  localparam logic [REG_AW-1:0] RI_PCTL = 4'd0;
  localparam logic [REG_AW-1:0] RI_WLO  = 4'd1;
  localparam logic [REG_AW-1:0] RI_WHI  = 4'd2;
  localparam logic [REG_AW-1:0] RI_ADDR = 4'd3;
  localparam logic [REG_AW-1:0] RI_CTRL = 4'd4;
  localparam logic [REG_AW-1:0] RI_ST0  = 4'd5;
  localparam logic [REG_AW-1:0] RI_ST1  = 4'd6;
  localparam logic [REG_AW-1:0] RI_RLO  = 4'd7;
  localparam logic [REG_AW-1:0] RI_RHI  = 4'd8;

  localparam int PC_ACCESS = 15;
  localparam int PC_CHKOFF = 9;
  localparam int PC_EXTWR  = 8;
  localparam int ADDR_LSB  = 6;
  localparam int S0_READY  = 3;
  localparam int S0_PROGOK = 2;
  localparam int S1_DONE   = 1;
  localparam int S1_CHKERR = 17;

  localparam logic [CMD_W-1:0] OP_READ   = 4'd0;
  localparam logic [CMD_W-1:0] OP_UNLOCK = 4'd2;
  localparam logic [CMD_W-1:0] OP_PROG   = 4'd10;

  function automatic logic [DATA_W-1:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    unlock_key = 32'h0000_000F;
      2'd1:    unlock_key = 32'h0000_0004;
      2'd2:    unlock_key = 32'h0000_0008;
      default: unlock_key = 32'h0000_000D;
    endcase
  endfunction

  function automatic logic [EXT_W-1:0] check_fold(input logic [DATA_W-1:0] d);
    logic [EXT_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++) r[i % EXT_W] = r[i % EXT_W] ^ d[i];
    return r;
  endfunction
endpackage

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int ROW_AW      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              start_nxt,
  input  logic              start_cur,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic [ROW_AW-1:0] row_in,
  input  logic [DATA_W-1:0] wlo_in,
  input  logic [EXT_W-1:0]  whi_in,
  input  logic              extwr_in,
  input  logic              chkoff_in,
  output logic              busy,
  output logic              fin,
  output logic [CMD_W-1:0]  l_cmd,
  output logic [ROW_AW-1:0] l_row,
  output logic [DATA_W-1:0] l_wlo,
  output logic [EXT_W-1:0]  l_whi,
  output logic              l_extwr,
  output logic              l_chkoff
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             launch;

  assign busy   = (cnt_q != '0);
  assign fin    = (cnt_q == CNT_W'(1));
  assign launch = start_nxt && !start_cur && cpu_en && !busy;

  always_comb begin
    cnt_d = cnt_q;
    if (launch)    cnt_d = CNT_W'(BUSY_CYCLES);
    else if (busy) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_cmd <= '0; l_row <= '0; l_wlo <= '0; l_whi <= '0;
      l_extwr <= 1'b0; l_chkoff <= 1'b0;
    end else if (launch) begin
      l_cmd <= cmd_in; l_row <= row_in; l_wlo <= wlo_in; l_whi <= whi_in;
      l_extwr <= extwr_in; l_chkoff <= chkoff_in;
    end
  end

  p_no_launch_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_en && !busy) |=> !busy);
  p_busy_holds_params_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(l_row) && $stable(l_cmd));
endmodule

// File: rtl/otp_unlock_track.sv
module otp_unlock_track
  import otp_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              fin,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] wlo,
  output logic              prog_ok
);
  localparam int STG_W = $clog2(KEY_LEN);
  localparam logic [STG_W-1:0] LAST = STG_W'(KEY_LEN - 1);

  logic [STG_W-1:0] stage_q, stage_d;
  logic             ok_q, ok_d;

  always_comb begin
    stage_d = stage_q;
    ok_d    = ok_q;
    if (!cpu_en) begin
      stage_d = '0;
      ok_d    = 1'b0;
    end else if (fin) begin
      if (cmd == OP_UNLOCK) begin
        if (wlo == unlock_key(stage_q)) begin
          if (stage_q == LAST) begin
            ok_d    = 1'b1;
            stage_d = '0;
          end else begin
            stage_d = stage_q + STG_W'(1);
          end
        end else begin
          stage_d = '0;
        end
      end else begin
        stage_d = '0;
        if (cmd == OP_PROG) ok_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ok_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      ok_q    <= ok_d;
    end
  end

  assign prog_ok = ok_q;

  p_ok_needs_last_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(fin && cmd == OP_UNLOCK && wlo == unlock_key(2'd3)));
  p_ok_drop_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> !ok_q);
endmodule

// File: rtl/otp_row_array.sv
module otp_row_array
  import otp_cmd_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int ROW_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ROW_AW-1:0] row,
  input  logic [DATA_W-1:0] wlo,
  input  logic [EXT_W-1:0]  whi,
  input  logic              extwr,
  input  logic              chkoff,
  input  logic              prog_ok,
  output logic [DATA_W-1:0] rd_lo,
  output logic [EXT_W-1:0]  rd_hi,
  output logic              chk_err
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] cur, merged;
  logic             do_prog, do_read;

  assign cur     = mem[row];
  assign merged  = cur | {(extwr ? whi : {EXT_W{1'b0}}), wlo};
  assign do_prog = fin && (cmd == OP_PROG) && prog_ok;
  assign do_read = fin && (cmd == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (do_prog) begin
      mem[row] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lo <= '0; rd_hi <= '0; chk_err <= 1'b0;
    end else if (do_read) begin
      rd_lo   <= cur[DATA_W-1:0];
      rd_hi   <= cur[ROW_W-1:DATA_W];
      chk_err <= !chkoff && (check_fold(cur[DATA_W-1:0]) != cur[ROW_W-1:DATA_W]);
    end
  end

  p_fuse_only_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cmd == OP_PROG) |=> ((cur & $past(cur)) == $past(cur)));
  p_locked_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cmd == OP_PROG && !prog_ok) |=> (cur == $past(cur)));
endmodule

// File: rtl/otp_cmd_front.sv
module otp_cmd_front
  import otp_cmd_pkg::*;
#(
  parameter int ROWS        = 1024,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  localparam int ROW_AW = $clog2(ROWS);

  logic              acc_q, acc_d, chkoff_q, chkoff_d, extwr_q, extwr_d;
  logic [DATA_W-1:0] wlo_q, wlo_d;
  logic [EXT_W-1:0]  whi_q, whi_d;
  logic [ROW_AW-1:0] row_q, row_d;
  logic              start_q, start_d, done_q, done_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [31:0]       rdata_d;

  logic              busy, fin, prog_ok, l_extwr, l_chkoff, chk_err;
  logic [CMD_W-1:0]  l_cmd;
  logic [ROW_AW-1:0] l_row;
  logic [DATA_W-1:0] l_wlo, rd_lo;
  logic [EXT_W-1:0]  l_whi, rd_hi;

  always_comb begin
    acc_d = acc_q; chkoff_d = chkoff_q; extwr_d = extwr_q;
    wlo_d = wlo_q; whi_d = whi_q; row_d = row_q;
    start_d = start_q; cmd_d = cmd_q; done_d = done_q;
    if (bus_wr) begin
      case (bus_addr)
        RI_PCTL: begin
          acc_d    = bus_wdata[PC_ACCESS];
          chkoff_d = bus_wdata[PC_CHKOFF];
          extwr_d  = bus_wdata[PC_EXTWR];
        end
        RI_WLO:  wlo_d = bus_wdata;
        RI_WHI:  whi_d = bus_wdata[EXT_W-1:0];
        RI_ADDR: row_d = bus_wdata[ADDR_LSB +: ROW_AW];
        RI_CTRL: begin
          start_d = bus_wdata[0];
          cmd_d   = bus_wdata[CMD_W:1];
        end
        RI_ST1:  if (bus_wdata[S1_DONE]) done_d = 1'b0;
        default: ;
      endcase
    end
    if (fin) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0; chkoff_q <= 1'b0; extwr_q <= 1'b0;
      wlo_q <= '0; whi_q <= '0; row_q <= '0;
      start_q <= 1'b0; cmd_q <= '0; done_q <= 1'b0;
    end else begin
      acc_q <= acc_d; chkoff_q <= chkoff_d; extwr_q <= extwr_d;
      wlo_q <= wlo_d; whi_q <= whi_d; row_q <= row_d;
      start_q <= start_d; cmd_q <= cmd_d; done_q <= done_d;
    end
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      RI_PCTL: begin
        rdata_d[PC_ACCESS] = acc_q;
        rdata_d[PC_CHKOFF] = chkoff_q;
        rdata_d[PC_EXTWR]  = extwr_q;
      end
      RI_WLO:  rdata_d = wlo_q;
      RI_WHI:  rdata_d[EXT_W-1:0] = whi_q;
      RI_ADDR: rdata_d[ADDR_LSB +: ROW_AW] = row_q;
      RI_CTRL: rdata_d[CMD_W:0] = {cmd_q, start_q};
      RI_ST0: begin
        rdata_d[S0_READY]  = !busy;
        rdata_d[S0_PROGOK] = prog_ok;
      end
      RI_ST1: begin
        rdata_d[S1_DONE]   = done_q;
        rdata_d[S1_CHKERR] = chk_err;
      end
      RI_RLO:  rdata_d = rd_lo;
      RI_RHI:  rdata_d[EXT_W-1:0] = rd_hi;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  otp_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES), .ROW_AW(ROW_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_en(acc_q),
    .start_nxt(start_d), .start_cur(start_q),
    .cmd_in(cmd_d), .row_in(row_q), .wlo_in(wlo_q), .whi_in(whi_q),
    .extwr_in(extwr_q), .chkoff_in(chkoff_q),
    .busy(busy), .fin(fin), .l_cmd(l_cmd), .l_row(l_row), .l_wlo(l_wlo),
    .l_whi(l_whi), .l_extwr(l_extwr), .l_chkoff(l_chkoff));

  otp_unlock_track u_lock (
    .clk(clk), .rst_n(rst_n), .cpu_en(acc_q), .fin(fin),
    .cmd(l_cmd), .wlo(l_wlo), .prog_ok(prog_ok));

  otp_row_array #(.ROWS(ROWS), .ROW_AW(ROW_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .fin(fin), .cmd(l_cmd), .row(l_row),
    .wlo(l_wlo), .whi(l_whi), .extwr(l_extwr), .chkoff(l_chkoff),
    .prog_ok(prog_ok), .rd_lo(rd_lo), .rd_hi(rd_hi), .chk_err(chk_err));

  p_done_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RI_ST1 && bus_wdata[S1_DONE] && !fin) |=> !done_q);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(bus_wr && bus_addr == RI_ST1)) |=> done_q);
endmodule

// File: tb/otp_cmd_front_test.sv
module otp_cmd_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 4;
  localparam int NROWS = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [40:0] model [NROWS];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_cmd_front #(.ROWS(NROWS), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  function automatic logic [8:0] fold9(input logic [31:0] d);
    logic [8:0] r = '0;
    for (int i = 0; i < 32; i++) r[i % 9] ^= d[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pctl(input bit en, input bit off, input bit ew);
    wr(4'd0, (32'(en) << 15) | (32'(off) << 9) | (32'(ew) << 8));
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(4'd6, v);
      if (v[1]) break;
    end
    wr(4'd6, 32'h2);
  endtask

  task automatic issue(input logic [3:0] cmd, input logic [31:0] lo);
    wr(4'd1, lo);
    wr(4'd4, {27'd0, cmd, 1'b0});
    wr(4'd4, {27'd0, cmd, 1'b1});
    wait_done();
    wr(4'd4, {27'd0, cmd, 1'b0});
  endtask

  task automatic unlock();
    issue(4'd2, 32'hF); issue(4'd2, 32'h4); issue(4'd2, 32'h8); issue(4'd2, 32'hD);
  endtask

  task automatic program_row(input int row, input logic [31:0] lo, input logic [8:0] hi, input bit ew, input bit ok);
    wr(4'd3, 32'(row) << 6);
    wr(4'd2, {23'd0, hi});
    issue(4'd10, lo);
    if (ok) model[row] = model[row] | {(ew ? hi : 9'd0), lo};
  endtask

  task automatic read_row(input int row, input bit off, input string tag);
    logic [31:0] v;
    bit experr;
    wr(4'd3, 32'(row) << 6);
    issue(4'd0, 32'd0);
    rd(4'd7, v); chk({tag, " R11 data low"}, v, model[row][31:0]);
    rd(4'd8, v); chk({tag, " R11 ext bits"}, v, {23'd0, model[row][40:32]});
    experr = !off && (fold9(model[row][31:0]) != model[row][40:32]);
    rd(4'd6, v); chk({tag, " R12 check error flag"}, v, {14'd0, experr, 17'd0});
  endtask

  task automatic chk_ok(input string tag, input bit exp);
    logic [31:0] v;
    rd(4'd5, v);
    chk(tag, v, 32'h8 | (32'(exp) << 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < NROWS; i++) model[i] = '0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd5, v); chk("R1 status0", v, 32'h8);
    rd(4'd6, v); chk("R1 status1", v, 32'h0);
    rd(4'd0, v); chk("R1 prog control", v, 32'h0);
    rd(4'd4, v); chk("R1 control", v, 32'h0);

    // R3 start with access disabled; R2 control field mask
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); chk("R2 control mask", v, 32'h1F);
    repeat (10) @(negedge clk);
    rd(4'd6, v); chk("R3 no launch while disabled", v, 32'h0);
    rd(4'd5, v); chk("R3 ready while disabled", v, 32'h8);

    // R2 masks
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R2 prog control mask", v, 32'h8300);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R2 address mask", v, 32'hFFC0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R2 write data high mask", v, 32'h1FF);

    // R3 start already high: no edge
    wr(4'd4, 32'hFFFF_FFFF);
    repeat (10) @(negedge clk);
    rd(4'd6, v); chk("R3 no launch without edge", v, 32'h0);
    wr(4'd4, 32'h0);
    set_pctl(1, 0, 0);

    // R4 latency: read command to row 0
    wr(4'd3, 32'h0);
    wr(4'd4, 32'h0);
    wr(4'd4, 32'h1);
    for (int i = 0; i < BUSY; i++) begin
      rd(4'd6, v); chk("R4 done not early", v, 32'h0);
    end
    rd(4'd6, v); chk("R4 done on time", v, 32'h2);
    rd(4'd5, v); chk("R4 ready back", v, 32'h8);

    // R5 write-one-to-clear
    wr(4'd6, 32'h0);
    rd(4'd6, v); chk("R5 zero write keeps done", v, 32'h2);
    wr(4'd6, 32'h2);
    rd(4'd6, v); chk("R5 one clears done", v, 32'h0);
    wr(4'd4, 32'h0);

    // R9 program refused without unlock
    program_row(5, 32'h1234_5678, 9'h1FF, 1, 0);
    read_row(5, 0, "R9 locked program");

    // R6 unlock sequence
    unlock();
    chk_ok("R6 unlocked", 1);

    // R10 OR behaviour, extension write disabled, consumes permission
    set_pctl(1, 0, 0);
    program_row(5, 32'h0000_00FF, 9'h1AB, 0, 1);
    chk_ok("R10 permission consumed", 0);
    unlock();
    program_row(5, 32'hF000_0000, 9'h0, 0, 1);
    read_row(5, 0, "R10 merge");
    chk("R10 merged value", model[5][31:0], 32'hF000_00FF);

    // R7 wrong key and other command mid-sequence
    issue(4'd2, 32'hF); issue(4'd2, 32'h4); issue(4'd2, 32'h5);
    issue(4'd2, 32'h8); issue(4'd2, 32'hD);
    chk_ok("R7 wrong key restarts", 0);
    issue(4'd2, 32'hF); issue(4'd2, 32'h4); issue(4'd0, 32'h0);
    issue(4'd2, 32'h8); issue(4'd2, 32'hD);
    chk_ok("R7 other command restarts", 0);
    unlock();
    chk_ok("R7 full sequence after restart", 1);

    // R8 disabling access drops permission and progress
    set_pctl(0, 0, 0);
    set_pctl(1, 0, 0);
    chk_ok("R8 disable clears permission", 0);
    issue(4'd2, 32'hF); issue(4'd2, 32'h4); issue(4'd2, 32'h8);
    set_pctl(0, 0, 0);
    set_pctl(1, 0, 0);
    issue(4'd2, 32'hD);
    chk_ok("R8 disable restarts sequence", 0);

    // R12 check bits good / bad / disabled
    set_pctl(1, 0, 1);
    unlock();
    program_row(9, 32'hCAFE_0001, fold9(32'hCAFE_0001), 1, 1);
    read_row(9, 0, "R12 good check");
    unlock();
    program_row(10, 32'h0000_0003, 9'h000, 1, 1);
    set_pctl(1, 0, 0);
    read_row(10, 0, "R12 bad check");
    set_pctl(1, 1, 0);
    read_row(10, 1, "R12 checking off");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int row;
      logic [31:0] lo;
      logic [8:0] hi;
      bit ew, ok, off;
      row = (it % 5 == 0) ? 5 : int'($urandom % NROWS);
      lo = $urandom;
      hi = 9'($urandom);
      ew = 1'($urandom);
      ok = ($urandom % 4) != 0;
      off = 1'($urandom);
      set_pctl(1, 0, ew);
      if (ok) unlock();
      program_row(row, lo, hi, ew, ok);
      chk_ok("R10 permission after program", 0);
      set_pctl(1, off, 0);
      read_row(row, off, "R11 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule